// File: doc/BRIEF.md
# Dual-Port Parallel I/O Controller

This block gives a processor two independent 8-bit parallel ports, A and B, on a small I/O bus of four consecutive addresses. Each port has a read/write data register and a write-only control register. A port is set up by writing a short sequence of control words to its control address. These words select the port's mode, set a per-pin direction mask when the port is in bit-control mode, turn its interrupt on or off, and load its interrupt vector.

In byte output mode the port drives all eight pins and reports each finished transfer through a ready/strobe handshake. In byte input mode a strobe from the peripheral captures the pins into the data register. Ready stays low until the processor has read that byte. Either kind of event can set the port's pending flag. The interrupt request output is the OR of both flags. During an acknowledge cycle the block places the vector of the serviced port on the read bus, with Port A taking priority over Port B, and clears only that port's flag.

Top module: `pario_dual`

## Requirements
- R1: Address 0 is Port A data, 1 is Port A control, 2 is Port B data and 3 is Port B control. A read of address 1 or 3 returns 0x00. With no read and no acknowledge, the read bus is 0x00.
- R2: After reset, both ports are in byte input mode with all pins undriven (oe = 0x00), ready is high, interrupts are disabled and irq is low.
- R3: A control word whose low nibble is 0xF selects a mode from bits [7:6]: 00 is byte output, 01 is byte input, 11 is bit control. Code 10 leaves the mode unchanged.
- R4: In byte output mode, oe is 0xFF and the pins carry the last byte written to the data register. A read of the data register returns that byte.
- R5: In byte output mode, a data write raises ready one clock later. A strobe rising edge while ready is high lowers ready and, if interrupts are enabled, sets the port's pending flag. A strobe edge while ready is low has no effect.
- R6: In byte input mode, a strobe rising edge captures the pins into the data register and lowers ready. A read of the data register returns the captured byte and raises ready again. Later changes on the pins do not alter the captured byte.
- R7: After a bit-control mode word, the next control word is always stored as the direction mask (1 = input) and is not decoded as any command. oe is the inverse of the mask, and the driven pins carry the data register bits where oe is 1. A data read returns the pins on input bits and the data register on output bits.
- R8: A control word with bit 0 = 0 that is not taken as a mask is stored as that port's interrupt vector.
- R9: A control word with low nibble 0x7 sets the port's interrupt enable from bit 7. While interrupts are disabled, events do not set the pending flag. Disabling interrupts discards a flag that is already set.
- R10: irq is high while either pending flag is set. During int_ack the read bus carries Port A's vector if A is pending, or else Port B's vector. The acknowledge clears only the serviced port's flag.
- R11: The ports are independent: programming or using one port does not change the mode, pins or ready of the other.
- R12: In bit-control mode the strobe is ignored. Ready stays low and no pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset: bit 1 picks the port, bit 0 picks control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data or vector, valid in the same cycle as bus_rd or int_ack |
| int_ack | input | 1 | Interrupt acknowledge, one cycle |
| irq | output | 1 | Interrupt request, active high |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A per-pin drive enable |
| pa_stb | input | 1 | Port A peripheral strobe |
| pa_rdy | output | 1 | Port A ready |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B per-pin drive enable |
| pb_stb | input | 1 | Port B peripheral strobe |
| pb_rdy | output | 1 | Port B ready |

## Verification
Read data and vectors are combinational, so they are sampled 1 ns after the falling edge where bus_rd or int_ack is raised, within the same cycle. Register effects appear after the next rising edge: pins, oe and mode after a control or data write, ready and irq after a strobe's first sampled high, and cleared flags after an acknowledge. The bench samples each of these at the following falling edge. It sweeps every data byte in output and input mode and every direction mask in bit-control mode, and computes the expected pins and read-back values from the requirement formulas.

// File: rtl/pario_pkg.sv
// Shared types for the dual parallel port controller.
// Assumes an 8-bit control word whose low nibble carries the command code.
package pario_pkg;
    localparam int PARIO_DW = 8;
    localparam int PARIO_NP = 2;

    typedef enum logic [1:0] {
        PM_OUT   = 2'b00,
        PM_IN    = 2'b01,
        PM_BIDIR = 2'b10,
        PM_BIT   = 2'b11
    } pmode_t;
endpackage

// File: rtl/pario_ctrl.sv
// Control word decoder for one port.
// Holds the mode, the direction mask, the interrupt enable and the vector.
// The word that follows a bit-control mode word is always taken as the mask.
// The next-state values are also output, so that the port logic can act
// in the same cycle. Assumes DW >= 8.
module pario_ctrl
    import pario_pkg::*;
#(
    parameter int DW = PARIO_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output pmode_t        mode,
    output pmode_t        mode_nxt,
    output logic          mode_load,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] vector,
    output logic          irq_en,
    output logic          irq_en_nxt
);
    localparam logic [3:0] CMD_MODE = 4'hF;
    localparam logic [3:0] CMD_IRQ  = 4'h7;

    logic   want_mask, want_mask_nxt;
    logic   mask_load, vec_load;
    pmode_t sel_mode;

    assign sel_mode = pmode_t'(wdata[DW-1:DW-2]);

    // Decode one control word into load strobes and next-state values.
    always_comb begin
        mode_load     = 1'b0;
        mode_nxt      = mode;
        irq_en_nxt    = irq_en;
        mask_load     = 1'b0;
        vec_load      = 1'b0;
        want_mask_nxt = want_mask;
        if (wr) begin
            if (want_mask) begin
                mask_load     = 1'b1;
                want_mask_nxt = 1'b0;
            end else if (wdata[3:0] == CMD_MODE) begin
                if (sel_mode != PM_BIDIR) begin
                    mode_load     = 1'b1;
                    mode_nxt      = sel_mode;
                    want_mask_nxt = (sel_mode == PM_BIT);
                end
            end else if (wdata[3:0] == CMD_IRQ) begin
                irq_en_nxt = wdata[DW-1];
            end else if (!wdata[0]) begin
                vec_load = 1'b1;
            end
        end
    end

    // Hold the port configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= PM_IN;
            mask      <= '1;
            vector    <= '0;
            irq_en    <= 1'b0;
            want_mask <= 1'b0;
        end else begin
            mode      <= mode_nxt;
            irq_en    <= irq_en_nxt;
            want_mask <= want_mask_nxt;
            if (mask_load) mask <= wdata;
            if (vec_load)  vector <= wdata;
        end
    end

    // R7
    mask_not_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (want_mask && wr) |=> (mode == $past(mode) && vector == $past(vector)
                               && irq_en == $past(irq_en) && mask == $past(wdata)));

    // R3
    bidir_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !want_mask && wdata[3:0] == CMD_MODE && wdata[DW-1:DW-2] == 2'b10)
        |=> mode == $past(mode));
endmodule

// File: rtl/pario_port.sv
// One parallel port: the data registers, pin drive, ready/strobe handshake
// and the pending flag. The strobe is assumed to be synchronous to clk;
// its rising edge is found against a registered copy. If a new event and
// an acknowledge fall in the same cycle, the new event wins.
module pario_port
    import pario_pkg::*;
#(
    parameter int DW = PARIO_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          ack,
    input  logic [DW-1:0] pins_in,
    input  logic          stb,
    output logic [DW-1:0] pins_out,
    output logic [DW-1:0] pins_oe,
    output logic          rdy,
    output logic          pend,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] vector
);
    pmode_t        mode, mode_nxt;
    logic          mode_load;
    logic [DW-1:0] mask;
    logic          irq_en, irq_en_nxt;
    logic          stb_q, rise, event_set;
    logic [DW-1:0] out_reg, in_latch;

    pario_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ctrl_wr),
        .wdata      (wdata),
        .mode       (mode),
        .mode_nxt   (mode_nxt),
        .mode_load  (mode_load),
        .mask       (mask),
        .vector     (vector),
        .irq_en     (irq_en),
        .irq_en_nxt (irq_en_nxt)
    );

    assign rise = stb & ~stb_q;
    assign event_set = rise && ((mode == PM_OUT && rdy) || mode == PM_IN);

    // Pick the per-pin drive enable from the mode.
    always_comb begin
        case (mode)
            PM_OUT:  pins_oe = '1;
            PM_BIT:  pins_oe = ~mask;
            default: pins_oe = '0;
        endcase
    end

    assign pins_out = out_reg & pins_oe;

    // Select what a data read returns for the current mode.
    always_comb begin
        case (mode)
            PM_OUT:  rdata = out_reg;
            PM_IN:   rdata = in_latch;
            PM_BIT:  rdata = (pins_in & mask) | (out_reg & ~mask);
            default: rdata = '0;
        endcase
    end

    // Data registers, the strobe edge history and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q    <= 1'b0;
            out_reg  <= '0;
            in_latch <= '0;
            pend     <= 1'b0;
        end else begin
            stb_q <= stb;
            if (data_wr) out_reg <= wdata;
            if (mode == PM_IN && rise) in_latch <= pins_in;
            pend <= irq_en_nxt & (event_set | (pend & ~ack));
        end
    end

    // Ready handshake per mode; a mode change sets the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b1;
        end else if (mode_load) begin
            rdy <= (mode_nxt == PM_IN);
        end else begin
            case (mode)
                PM_OUT: begin
                    if (data_wr)   rdy <= 1'b1;
                    else if (rise) rdy <= 1'b0;
                end
                PM_IN: begin
                    if (rise)         rdy <= 1'b0;
                    else if (data_rd) rdy <= 1'b1;
                end
                default: rdy <= 1'b0;
            endcase
        end
    end

    // R5
    out_hs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OUT && rise && rdy && !data_wr && !mode_load) |=> !rdy);

    // R6
    in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IN && rise) |=> in_latch == $past(pins_in));

    // R9
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !pend);

    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !event_set) |=> !pend);

    // R12
    bit_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_BIT && !pend && !mode_load) |=> !pend);
endmodule

// File: rtl/pario_arb.sv
// Fixed-priority interrupt arbiter: the lowest index (Port A) wins.
// The grant is combinational and is only used during an acknowledge.
module pario_arb #(
    parameter int NP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pend,
    output logic [NP-1:0] grant
);
    // Grant the first pending requester in index order.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NP; i++) begin
            if (pend[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // R10
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|pend) == (|grant)));
endmodule

// File: rtl/pario_dual.sv
// Top level: two parallel ports on a four-address I/O bus.
// Decodes the bus (bit 1 = port, bit 0 = control), muxes the read data
// and the acknowledge vector, and ORs the pending flags into irq.
// Assumes that bus_wr, bus_rd and int_ack are single-cycle and never
// asserted in the same cycle.
module pario_dual
    import pario_pkg::*;
#(
    parameter int DW = PARIO_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          int_ack,
    output logic          irq,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic          pa_stb,
    output logic          pa_rdy,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic          pb_stb,
    output logic          pb_rdy
);
    localparam int NP = PARIO_NP;

    logic [DW-1:0] p_in   [NP];
    logic [DW-1:0] p_out  [NP];
    logic [DW-1:0] p_oe   [NP];
    logic [DW-1:0] p_rd   [NP];
    logic [DW-1:0] p_vec  [NP];
    logic [NP-1:0] p_stb, p_rdy, pend, grant;

    assign p_in[0]  = pa_in;
    assign p_in[1]  = pb_in;
    assign p_stb    = {pb_stb, pa_stb};
    assign pa_out   = p_out[0];
    assign pb_out   = p_out[1];
    assign pa_oe    = p_oe[0];
    assign pb_oe    = p_oe[1];
    assign pa_rdy   = p_rdy[0];
    assign pb_rdy   = p_rdy[1];

    for (genvar g = 0; g < NP; g++) begin : g_port
        logic sel;
        assign sel = (bus_addr[1] == g[0]);
        pario_port #(.DW(DW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .data_wr  (bus_wr & sel & ~bus_addr[0]),
            .data_rd  (bus_rd & sel & ~bus_addr[0]),
            .ctrl_wr  (bus_wr & sel &  bus_addr[0]),
            .wdata    (bus_wdata),
            .ack      (int_ack & grant[g]),
            .pins_in  (p_in[g]),
            .stb      (p_stb[g]),
            .pins_out (p_out[g]),
            .pins_oe  (p_oe[g]),
            .rdy      (p_rdy[g]),
            .pend     (pend[g]),
            .rdata    (p_rd[g]),
            .vector   (p_vec[g])
        );
    end

    pario_arb #(.NP(NP)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .grant (grant)
    );

    assign irq = |pend;

    // Drive the vector during acknowledge, else the addressed data register.
    always_comb begin
        bus_rdata = '0;
        if (int_ack) begin
            for (int i = 0; i < NP; i++)
                if (grant[i]) bus_rdata = p_vec[i];
        end else if (bus_rd && !bus_addr[0]) begin
            bus_rdata = p_rd[bus_addr[1]];
        end
    end

    // R1
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[0] && !int_ack) |-> bus_rdata == '0);

    // R10
    ack_prio_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && pend[0]) |-> bus_rdata == p_vec[0]);

    // R10
    ack_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !pend[0] && pend[1]) |-> bus_rdata == p_vec[1]);
endmodule

// File: tb/pario_dual_bench.sv
// Self-checking bench: sweeps data bytes and direction masks and computes
// the expected pins and read-back values from the requirement formulas.
module pario_dual_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, int_ack = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq;
    logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
    logic       pa_stb = 1'b0, pb_stb = 1'b0, pa_rdy, pb_rdy;

    int  nchk = 0, nfail = 0;
    bit  done = 1'b0;

    pario_dual u_pario_dual (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_ack(int_ack), .irq(irq),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pa_stb(pa_stb), .pa_rdy(pa_rdy),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pb_stb(pb_stb), .pb_rdy(pb_rdy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk); int_ack = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); int_ack = 1'b0;
    endtask

    task automatic strobe(input bit a, input bit b);
        @(negedge clk); pa_stb = a; pb_stb = b;
        @(negedge clk); pa_stb = 1'b0; pb_stb = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 pa_oe", pa_oe, 8'h00);
        chk("R2 pb_oe", pb_oe, 8'h00);
        chk("R2 irq", {7'd0, irq}, 8'h00);
        chk("R2 pa_rdy", {7'd0, pa_rdy}, 8'h01);
        chk("R2 pb_rdy", {7'd0, pb_rdy}, 8'h01);
        // R1 control reads and the idle bus
        rd(2'd1, v); chk("R1 ctrl A read", v, 8'h00);
        rd(2'd3, v); chk("R1 ctrl B read", v, 8'h00);
        chk("R1 idle bus", bus_rdata, 8'h00);

        // R3 / R4 / R5: byte output sweep on A
        wr(2'd1, 8'h0F);
        chk("R3 out mode oe", pa_oe, 8'hFF);
        chk("R5 rdy low after mode", {7'd0, pa_rdy}, 8'h00);
        for (int i = 0; i < 256; i++) begin
            wr(2'd0, i[7:0]);
            chk("R4 pins", pa_out, i[7:0]);
            chk("R5 rdy after write", {7'd0, pa_rdy}, 8'h01);
            rd(2'd0, v); chk("R4 readback", v, i[7:0]);
            chk("R11 B undriven", pb_oe, 8'h00);
        end

        // R8 / R9 / R5 / R10: output handshake with an interrupt
        wr(2'd1, 8'h40);
        wr(2'd1, 8'h87);
        wr(2'd0, 8'h5A);
        strobe(1'b1, 1'b0);
        chk("R5 rdy cleared", {7'd0, pa_rdy}, 8'h00);
        chk("R5 irq set", {7'd0, irq}, 8'h01);
        ack(v); chk("R8 vector A", v, 8'h40);
        @(negedge clk);
        chk("R10 irq cleared", {7'd0, irq}, 8'h00);
        strobe(1'b1, 1'b0);
        chk("R5 strobe while not ready", {7'd0, irq}, 8'h00);

        // R6: byte input sweep on B with an interrupt per byte
        wr(2'd3, 8'h52);
        wr(2'd3, 8'h87);
        wr(2'd3, 8'h4F);
        chk("R11 A still driven", pa_oe, 8'hFF);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); pb_in = i[7:0];
            strobe(1'b0, 1'b1);
            pb_in = ~i[7:0];
            chk("R6 rdy low", {7'd0, pb_rdy}, 8'h00);
            chk("R6 irq", {7'd0, irq}, 8'h01);
            rd(2'd2, v); chk("R6 captured", v, i[7:0]);
            chk("R6 rdy restored", {7'd0, pb_rdy}, 8'h01);
            ack(v); chk("R10 vector B", v, 8'h52);
        end
        @(negedge clk);
        chk("R10 irq idle", {7'd0, irq}, 8'h00);

        // R10: priority when both ports are pending
        wr(2'd0, 8'h11);
        strobe(1'b1, 1'b1);
        chk("R10 both pending irq", {7'd0, irq}, 8'h01);
        ack(v); chk("R10 A first", v, 8'h40);
        chk("R10 B still pending", {7'd0, irq}, 8'h01);
        ack(v); chk("R10 B second", v, 8'h52);
        chk("R10 all serviced", {7'd0, irq}, 8'h00);
        rd(2'd2, v);

        // R9: disable blocks events and discards a set flag
        wr(2'd1, 8'h07);
        wr(2'd0, 8'h22);
        strobe(1'b1, 1'b0);
        chk("R9 disabled no irq", {7'd0, irq}, 8'h00);
        chk("R9 handshake still runs", {7'd0, pa_rdy}, 8'h00);
        wr(2'd1, 8'h87);
        wr(2'd0, 8'h23);
        strobe(1'b1, 1'b0);
        chk("R9 enabled irq", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h07);
        chk("R9 disable clears", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h87);
        chk("R9 flag discarded", {7'd0, irq}, 8'h00);

        // R7: bit-control sweep over every mask on A
        for (int m = 0; m < 256; m++) begin
            logic [7:0] d, p;
            d = m[7:0] ^ 8'hA5;
            p = {m[3:0], m[7:4]} ^ 8'h3C;
            wr(2'd1, 8'hCF);
            wr(2'd1, m[7:0]);
            wr(2'd0, d);
            pa_in = p;
            @(negedge clk);
            chk("R7 oe", pa_oe, ~m[7:0]);
            chk("R7 pins", pa_out, d & ~m[7:0]);
            rd(2'd0, v); chk("R7 read", v, (p & m[7:0]) | (d & ~m[7:0]));
        end

        // R12: strobe ignored in bit-control mode
        strobe(1'b1, 1'b0);
        chk("R12 no irq", {7'd0, irq}, 8'h00);
        chk("R12 rdy low", {7'd0, pa_rdy}, 8'h00);

        // R7 / R8: masks such as 0x06 did not reload the vector
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h33);
        strobe(1'b1, 1'b0);
        ack(v); chk("R7 vector kept", v, 8'h40);

        // R3: mode code 10 leaves both ports unchanged
        wr(2'd1, 8'h8F);
        chk("R3 A stays output", pa_oe, 8'hFF);
        wr(2'd3, 8'h8F);
        chk("R3 B stays input", pb_oe, 8'h00);
        wr(2'd3, 8'h0F);
        chk("R3 B to output", pb_oe, 8'hFF);
        wr(2'd3, 8'h4F);
        chk("R3 B back to input", pb_oe, 8'h00);
        chk("R3 B input rdy", {7'd0, pb_rdy}, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule